// File: doc/BRIEF.md
# Instruction Prefetch Byte Queue

This block keeps a short run of instruction bytes ready for a byte-wide decoder while a 16-bit bus engine fills it in the background. It holds up to six bytes in arrival order. Refill happens one 16-bit word at a time, each word entering as two bytes. The decoder removes bytes one per clock from the head. A fetch is requested only when two slots are free, no fetch is outstanding and the execution side has no operand transfer waiting.

The block also owns the code offset. It forms the 20-bit fetch address by adding the offset to the code segment shifted left by four. On a branch, the queue empties and the offset jumps to the target. A word still on the bus at that moment is dropped when it returns. A fetch from an odd offset keeps only the upper byte of the returned word, which brings the offset back to an even value. Every clock the block reports a two-bit code that says what happened to the queue on the previous clock edge.

Top module: `ifq_prefetch`

## Requirements
- R1: The queue holds at most 6 bytes and delivers them in arrival order; `byte_valid` is high exactly when the queue is not empty and `byte_out` is then the oldest byte.
- R2: `fetch_req` is high only when no fetch is outstanding, `opnd_req` and `branch_req` are low, and at least 2 slots are free (at most 4 bytes held); after a grant no new request is raised until `fetch_done`.
- R3: A returned word from an even offset enters as two bytes, bits 7:0 first and bits 15:8 second.
- R4: `take_byte` while the queue is empty has no effect: the queue stays empty and the next status is 00.
- R5: `branch_req` empties the queue at the next edge and loads the offset from `branch_ofs`.
- R6: `fetch_addr` equals (`code_seg` * 16 + offset) modulo 2^20; the offset is 0 after reset.
- R7: `q_status` is registered and describes the previous edge: 10 after a branch (which has priority), 01 when a byte was taken with `take_first` high, 11 when a byte was taken with `take_first` low, 00 when no byte was taken.
- R8: A word whose fetch was granted before a branch, or returns on the same edge as a branch, is discarded and the offset does not advance.
- R9: A word fetched from an odd offset writes only bits 15:8 and advances the offset by 1; a word from an even offset advances the offset by 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| code_seg | input | 16 | Code segment value |
| branch_req | input | 1 | Control transfer: flush and redirect |
| branch_ofs | input | 16 | New offset on a control transfer |
| opnd_req | input | 1 | Execution side wants an operand bus cycle |
| fetch_req | output | 1 | Request for one word fetch |
| fetch_addr | output | 20 | Fetch byte address |
| fetch_gnt | input | 1 | Bus accepts the request this clock |
| fetch_done | input | 1 | Requested word returns this clock |
| fetch_word | input | 16 | Returned word |
| take_byte | input | 1 | Decoder removes the head byte |
| take_first | input | 1 | The byte being taken starts an instruction |
| byte_valid | output | 1 | Head byte is available |
| byte_out | output | 8 | Head byte |
| q_status | output | 2 | Queue status code for the previous clock |

## Verification
The assertions assume that the bus engine obeys the request protocol: `fetch_gnt` only comes while `fetch_req` is high, and `fetch_done` only comes while a fetch is outstanding. They also assume that a grant and a return never share a clock. The bench stays inside these rules. It derives each grant from the sampled `fetch_req` and issues a return only when its own model records an outstanding fetch. The returned data is a fixed function of the granted address, so a word that arrives after a flush still carries its old contents.

// File: rtl/ifq_pkg.sv
package ifq_pkg;

   typedef enum logic [1:0] {
      QS_IDLE  = 2'b00,
      QS_FIRST = 2'b01,
      QS_FLUSH = 2'b10,
      QS_NEXT  = 2'b11
   } qstat_e;

endpackage

// File: rtl/ifq_slots.sv
module ifq_slots #(
   parameter int DEPTH = 6,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             pop_ok,
   input  logic [1:0]       push_n,
   input  logic [7:0]       push_b0,
   input  logic [7:0]       push_b1,
   output logic [7:0]       head,
   output logic [CNT_W-1:0] count
);

   logic [7:0] slot_w [DEPTH];
   logic [CNT_W:0] wpos;

   assign wpos = {1'b0, count} - {{CNT_W{1'b0}}, pop_ok};

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic [7:0] q;
      logic [7:0] shifted;
      if (i == DEPTH - 1) begin : g_last
         assign shifted = q;
      end else begin : g_mid
         assign shifted = pop_ok ? slot_w[i+1] : q;
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= '0;
         else if (push_n != 2'd0 && int'(wpos) == i)
            q <= push_b0;
         else if (push_n == 2'd2 && int'(wpos) + 1 == i)
            q <= push_b1;
         else
            q <= shifted;
      end
      assign slot_w[i] = q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count <= '0;
      else if (flush)
         count <= '0;
      else
         count <= CNT_W'(wpos + {{(CNT_W-1){1'b0}}, push_n});
   end

   assign head = slot_w[0];

   assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH));

endmodule

// File: rtl/ifq_fetch.sv
module ifq_fetch #(
   parameter int DEPTH     = 6,
   parameter int OFS_W     = 16,
   parameter int SEG_W     = 16,
   parameter int SEG_SHIFT = 4,
   parameter int ADDR_W    = 20,
   localparam int CNT_W    = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              branch,
   input  logic [OFS_W-1:0]  branch_ofs,
   input  logic [SEG_W-1:0]  code_seg,
   input  logic              opnd_req,
   input  logic [CNT_W-1:0]  count,
   input  logic              fetch_gnt,
   input  logic              fetch_done,
   input  logic [15:0]       fetch_word,
   output logic              fetch_req,
   output logic [ADDR_W-1:0] fetch_addr,
   output logic [1:0]        push_n,
   output logic [7:0]        push_b0,
   output logic [7:0]        push_b1
);

   logic [OFS_W-1:0] offset;
   logic busy, stale, accept;

   assign fetch_req = !busy && !opnd_req && !branch && (count <= CNT_W'(DEPTH - 2));
   assign accept    = fetch_done && busy && !stale && !branch;
   assign push_n    = accept ? (offset[0] ? 2'd1 : 2'd2) : 2'd0;
   assign push_b0   = offset[0] ? fetch_word[15:8] : fetch_word[7:0];
   assign push_b1   = fetch_word[15:8];

   assign fetch_addr = (ADDR_W'(code_seg) << SEG_SHIFT) + ADDR_W'(offset);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         stale <= 1'b0;
      end else if (fetch_done) begin
         busy  <= 1'b0;
         stale <= 1'b0;
      end else if (fetch_gnt && fetch_req) begin
         busy  <= 1'b1;
      end else if (branch && busy) begin
         stale <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         offset <= '0;
      else if (branch)
         offset <= branch_ofs;
      else if (accept)
         offset <= offset + (offset[0] ? OFS_W'(1) : OFS_W'(2));
   end

   assert_single_outstanding_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_gnt && fetch_req) |=> !fetch_req);
   assert_gnt_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_gnt |-> fetch_req);
   assert_done_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_done |-> busy);
   assert_odd_realign_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (push_n == 2'd1) |=> !fetch_addr[0]);

endmodule

// File: rtl/ifq_prefetch.sv
module ifq_prefetch #(
   parameter int DEPTH     = 6,
   parameter int OFS_W     = 16,
   parameter int SEG_W     = 16,
   parameter int SEG_SHIFT = 4,
   parameter int ADDR_W    = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SEG_W-1:0]  code_seg,
   input  logic              branch_req,
   input  logic [OFS_W-1:0]  branch_ofs,
   input  logic              opnd_req,
   output logic              fetch_req,
   output logic [ADDR_W-1:0] fetch_addr,
   input  logic              fetch_gnt,
   input  logic              fetch_done,
   input  logic [15:0]       fetch_word,
   input  logic              take_byte,
   input  logic              take_first,
   output logic              byte_valid,
   output logic [7:0]        byte_out,
   output logic [1:0]        q_status
);
   import ifq_pkg::*;

   localparam int CNT_W = $clog2(DEPTH + 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("ifq_prefetch: DEPTH must hold at least one fetched word");
   end
   if (ADDR_W < OFS_W) begin : g_bad_addr
      $error("ifq_prefetch: ADDR_W must cover the offset");
   end

   logic [CNT_W-1:0] count;
   logic [1:0] push_n;
   logic [7:0] push_b0, push_b1;
   logic pop_ok;
   qstat_e status_q;

   assign byte_valid = (count != '0);
   assign pop_ok     = take_byte && byte_valid && !branch_req;

   ifq_fetch #(
      .DEPTH(DEPTH), .OFS_W(OFS_W), .SEG_W(SEG_W),
      .SEG_SHIFT(SEG_SHIFT), .ADDR_W(ADDR_W)
   ) u_fetch (
      .clk(clk), .rst_n(rst_n), .branch(branch_req), .branch_ofs(branch_ofs),
      .code_seg(code_seg), .opnd_req(opnd_req), .count(count),
      .fetch_gnt(fetch_gnt), .fetch_done(fetch_done), .fetch_word(fetch_word),
      .fetch_req(fetch_req), .fetch_addr(fetch_addr),
      .push_n(push_n), .push_b0(push_b0), .push_b1(push_b1)
   );

   ifq_slots #(.DEPTH(DEPTH)) u_slots (
      .clk(clk), .rst_n(rst_n), .flush(branch_req), .pop_ok(pop_ok),
      .push_n(push_n), .push_b0(push_b0), .push_b1(push_b1),
      .head(byte_out), .count(count)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         status_q <= QS_IDLE;
      else if (branch_req)
         status_q <= QS_FLUSH;
      else if (pop_ok)
         status_q <= take_first ? QS_FIRST : QS_NEXT;
      else
         status_q <= QS_IDLE;
   end

   assign q_status = status_q;

   assert_flush_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
      branch_req |=> !byte_valid);
   assert_flush_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
      branch_req |=> (q_status == 2'b10));
   assert_empty_take_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (take_byte && !byte_valid && !branch_req) |=> (q_status == 2'b00));
   assert_stale_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_done && branch_req) |=> (count == '0));

endmodule

// File: tb/tb_ifq_prefetch.sv
module tb_ifq_prefetch;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [15:0] code_seg = 16'h1234;
   logic branch_req = 1'b0;
   logic [15:0] branch_ofs = '0;
   logic opnd_req = 1'b0;
   logic fetch_req;
   logic [19:0] fetch_addr;
   logic fetch_gnt = 1'b0;
   logic fetch_done = 1'b0;
   logic [15:0] fetch_word = '0;
   logic take_byte = 1'b0;
   logic take_first = 1'b0;
   logic byte_valid;
   logic [7:0] byte_out;
   logic [1:0] q_status;

   always #10 clk = ~clk;

   ifq_prefetch dut (
      .clk(clk), .rst_n(rst_n), .code_seg(code_seg), .branch_req(branch_req),
      .branch_ofs(branch_ofs), .opnd_req(opnd_req), .fetch_req(fetch_req),
      .fetch_addr(fetch_addr), .fetch_gnt(fetch_gnt), .fetch_done(fetch_done),
      .fetch_word(fetch_word), .take_byte(take_byte), .take_first(take_first),
      .byte_valid(byte_valid), .byte_out(byte_out), .q_status(q_status)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   logic [7:0] mq [6];
   int mcnt = 0;
   logic [15:0] moff = '0;
   bit minfl = 1'b0;
   bit mstale = 1'b0;
   logic [19:0] maddr = '0;
   logic [1:0] mstat = 2'b00;

   function automatic logic [7:0] mem_byte(input logic [19:0] a);
      return a[7:0] ^ {a[11:8], a[15:12]} ^ {4'h0, a[19:16]} ^ 8'h3C;
   endfunction

   function automatic logic [15:0] mem_word(input logic [19:0] a);
      return {mem_byte({a[19:1], 1'b1}), mem_byte({a[19:1], 1'b0})};
   endfunction

   function automatic logic [19:0] exp_addr(input logic [15:0] seg, input logic [15:0] ofs);
      return ({4'h0, seg} << 4) + {4'h0, ofs};
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic step(input bit pop, input bit first, input bit br, input logic [15:0] tgt,
                       input logic [15:0] seg, input bit opnd, input bit allow_gnt, input bit do_done);
      bit exp_req, pv;
      @(negedge clk);
      take_byte  = pop;
      take_first = first;
      branch_req = br;
      branch_ofs = tgt;
      if (br) code_seg = seg;
      opnd_req   = opnd;
      fetch_done = do_done && minfl;
      fetch_word = mem_word(maddr);
      fetch_gnt  = 1'b0;
      #1;
      exp_req = !minfl && !opnd && !br && (mcnt <= 4);
      chk(fetch_req == exp_req, "R2 fetch_req", {31'd0, fetch_req}, {31'd0, exp_req});
      if (fetch_req)
         chk(fetch_addr == exp_addr(code_seg, moff), "R6 fetch_addr", {12'd0, fetch_addr},
             {12'd0, exp_addr(code_seg, moff)});
      fetch_gnt = allow_gnt && fetch_req;
      @(posedge clk);
      pv = pop && (mcnt > 0) && !br;
      mstat = br ? 2'b10 : (pv ? (first ? 2'b01 : 2'b11) : 2'b00);
      if (br) begin
         mcnt = 0;
         moff = tgt;
         if (fetch_done) begin minfl = 1'b0; mstale = 1'b0; end
         else if (minfl) mstale = 1'b1;
      end else begin
         if (pv) begin
            for (int i = 0; i < 5; i++) mq[i] = mq[i+1];
            mcnt--;
         end
         if (fetch_done) begin
            if (!mstale) begin
               if (moff[0]) begin
                  mq[mcnt] = fetch_word[15:8]; mcnt++; moff = moff + 16'd1;
               end else begin
                  mq[mcnt] = fetch_word[7:0]; mq[mcnt+1] = fetch_word[15:8];
                  mcnt += 2; moff = moff + 16'd2;
               end
            end
            minfl = 1'b0;
            mstale = 1'b0;
         end else if (fetch_gnt) begin
            minfl = 1'b1;
            maddr = fetch_addr;
         end
      end
      #1;
      chk(byte_valid == (mcnt > 0), "R1 byte_valid", {31'd0, byte_valid}, {31'd0, mcnt > 0});
      if (byte_valid && mcnt > 0)
         chk(byte_out == mq[0], "R3 byte_out order", {24'd0, byte_out}, {24'd0, mq[0]});
      chk(q_status == mstat, "R7 q_status", {30'd0, q_status}, {30'd0, mstat});
   endtask

   initial begin
      repeat (40000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk(byte_valid == 1'b0, "R1 reset empty", {31'd0, byte_valid}, 32'd0);
      chk(q_status == 2'b00, "R7 reset status", {30'd0, q_status}, 32'd0);
      chk(fetch_req == 1'b1, "R2 reset request", {31'd0, fetch_req}, 32'd1);
      chk(fetch_addr == 20'h12340, "R6 reset address", {12'd0, fetch_addr}, 32'h12340);

      // fill the queue with no consumer
      for (int k = 0; k < 14; k++) step(0, 0, 0, 16'h0, 16'h0, 0, 1, 1);
      chk(mcnt == 6 && fetch_req == 1'b0, "R2 full queue holds request off",
          {31'd0, fetch_req}, 32'd0);
      // drain in order, then take from empty
      for (int k = 0; k < 6; k++) step(1, k == 0, 0, 16'h0, 16'h0, 1, 0, 0);
      step(1, 1, 0, 16'h0, 16'h0, 1, 0, 0);
      chk(byte_valid == 1'b0 && q_status == 2'b00, "R4 take on empty ignored",
          {30'd0, byte_valid, q_status[0]}, 32'd0);
      // operand request blocks prefetch
      step(0, 0, 0, 16'h0, 16'h0, 1, 1, 0);
      // branch with a fetch in flight, to an odd target
      step(0, 0, 0, 16'h0, 16'h0, 0, 1, 0);
      step(1, 0, 1, 16'h0101, 16'h2000, 0, 0, 0);
      chk(byte_valid == 1'b0, "R5 branch empties queue", {31'd0, byte_valid}, 32'd0);
      chk(fetch_addr == 20'h20101, "R5 branch redirects fetch", {12'd0, fetch_addr}, 32'h20101);
      step(0, 0, 0, 16'h0, 16'h0, 1, 0, 1);
      chk(byte_valid == 1'b0, "R8 stale word discarded", {31'd0, byte_valid}, 32'd0);
      step(0, 0, 0, 16'h0, 16'h0, 0, 1, 0);
      step(0, 0, 0, 16'h0, 16'h0, 1, 0, 1);
      chk(byte_valid && byte_out == mem_byte(20'h20101), "R9 odd fetch keeps high byte",
          {24'd0, byte_out}, {24'd0, mem_byte(20'h20101)});
      chk(fetch_addr == 20'h20102, "R9 odd fetch realigns offset", {12'd0, fetch_addr}, 32'h20102);
      // branch on the same edge as a returning word
      step(0, 0, 0, 16'h0, 16'h0, 0, 1, 0);
      step(0, 0, 1, 16'h0040, 16'h0100, 0, 0, 1);
      chk(byte_valid == 1'b0 && fetch_addr == 20'h01040, "R8 same-edge word dropped",
          {12'd0, fetch_addr}, 32'h01040);

      // constrained random traffic
      for (int k = 0; k < 4000; k++) begin
         bit br = ($urandom_range(0, 99) < 3);
         step($urandom_range(0, 1), $urandom_range(0, 1), br,
              16'($urandom), 16'($urandom), ($urandom_range(0, 99) < 20),
              ($urandom_range(0, 99) < 70), ($urandom_range(0, 99) < 40));
      end

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule